// File: doc/BRIEF.md
# Permission-Tagged Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations for three kinds of access: data loads, data stores and instruction fetches. It keeps one frame array and three tag banks, one bank per access kind. A tag bank holds a page's tag only when that kind of access is allowed on the page. A single compare against the bank chosen by the access kind therefore covers both the address match and the permission check. A lookup that hits returns the physical address in the same cycle.

A lookup that misses parks the request. The block raises a level request to an external page walker and holds `req_ready_o` low until the walker returns a page-table entry. The block then derives the effective permissions: user bits in user mode, the supervisor bits moved down into the user positions in supervisor mode. It checks the permissions the access needs. On success it fills each tag bank according to its permission bit, writes the frame, and returns the physical address. On failure it reports an access fault for that kind, together with the faulting virtual address, and writes nothing. A flush input invalidates every tag in all three banks.

Top module: `perm_tag_tlb`

## Requirements
- R1: After reset no entry is valid: `req_ready_o` is 1, `resp_valid_o` and `walk_req_valid_o` are 0, and any lookup, including one to the highest virtual page, misses and sends a walk request.
- R2: The entry index is the virtual page number (address bits above bit 11) modulo 256, and a hit needs the full page number to match. Two pages with the same index evict each other, and neither ever hits on the other's entry.
- R3: A lookup that hits gives `resp_valid_o`=1 in the same cycle, with `resp_paddr_o` = {stored frame, low 12 address bits}, and sends no walk request.
- R4: A miss moves the block to a waiting state on the next clock edge. While waiting, `req_ready_o` is 0 and `walk_req_valid_o` is 1 with `walk_req_vaddr_o` held at the missed address, whatever the request inputs do. The response appears in the cycle `walk_resp_valid_i` is 1.
- R5: Entry format: bit 0 is valid, bits 1/2/3 are user read/write/execute, bits 4/5/6 are supervisor read/write/execute, and bits 63:12 are the frame. Access kind 0 is a load, 1 a store, 2 a fetch, and 3 is treated as a load. On a successful refill, the load, store and fetch banks each receive the page tag only if the effective read, write or execute bit is set.
- R6: When `req_sup_i` is 1 at the time of the miss, the effective permissions are entry bits 6:4 in place of bits 3:1. The valid bit is used as is.
- R7: A refill whose entry lacks the valid bit, or lacks the permission the access kind needs, sets `resp_fault_o`=1. `resp_cause_o` is then 1 for a load, 2 for a store or 3 for a fetch (0 when there is no fault), and `resp_badaddr_o` is the missed virtual address.
- R8: A faulting refill writes no tag, so the same lookup misses again.
- R9: A flush pulse invalidates the tags of all three banks, so the next load, store or fetch to a page that was cached misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all tags |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_vaddr_i | input | 64 | Lookup virtual address |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_sup_i | input | 1 | Supervisor mode for this lookup |
| resp_valid_o | output | 1 | Translation or fault result valid |
| resp_fault_o | output | 1 | Result is an access fault |
| resp_cause_o | output | 2 | Fault cause: 0 none, 1 load, 2 store, 3 fetch |
| resp_paddr_o | output | 64 | Translated physical address |
| resp_badaddr_o | output | 64 | Faulting virtual address |
| walk_req_valid_o | output | 1 | Page walk request (held until answered) |
| walk_req_vaddr_o | output | 64 | Address to walk |
| walk_resp_valid_i | input | 1 | Walker returns an entry |
| walk_resp_pte_i | input | 64 | Page-table entry from walker |

## Verification
The bound checker checks the following on every cycle: ready stays low during a walk, the walk address stays stable, a fault is reported only in a walker-response cycle and always carries the missed address and a cause, the page offset passes through to the physical address, and a hit or miss leads to the correct next control state. Only the directed scenarios can show the per-kind tag fill, the supervisor permission shift, eviction between aliasing pages, the absence of a fill after a fault, and invalidation by flush. These depend on what the tag banks hold across several lookups.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int PTE_W        = 64;
    localparam int PTE_V_BIT    = 0;
    localparam int USER_P_LSB   = 1;
    localparam int SUPER_P_LSB  = 4;
    localparam int NUM_KINDS    = 3;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LOAD  = 2'd1,
        CAUSE_STORE = 2'd2,
        CAUSE_FETCH = 2'd3
    } cause_e;

    // bit 0 read (load bank), bit 1 write (store bank), bit 2 execute (fetch bank)
    typedef logic [NUM_KINDS-1:0] perm_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } miss_state_e;

    function automatic perm_t effective_perm(input logic [PTE_W-1:0] pte, input logic sup);
        return sup ? pte[SUPER_P_LSB +: NUM_KINDS] : pte[USER_P_LSB +: NUM_KINDS];
    endfunction

    function automatic perm_t needed_perm(input logic [1:0] kind);
        case (kind)
            ACC_STORE: return 3'b010;
            ACC_FETCH: return 3'b100;
            default:   return 3'b001;
        endcase
    endfunction

    function automatic cause_e fault_cause(input logic [1:0] kind);
        case (kind)
            ACC_STORE: return CAUSE_STORE;
            ACC_FETCH: return CAUSE_FETCH;
            default:   return CAUSE_LOAD;
        endcase
    endfunction

    function automatic int bank_of(input logic [1:0] kind);
        case (kind)
            ACC_STORE: return 1;
            ACC_FETCH: return 2;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/ptlb_tag_bank.sv
module ptlb_tag_bank #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 53,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [TAG_W-1:0] rd_tag_o
);

    logic [TAG_W-1:0] tags_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags_q[i] <= '1;
            end
        end else if (wr_en_i) begin
            tags_q[wr_idx_i] <= wr_tag_i;
        end
    end

    assign rd_tag_o = tags_q[rd_idx_i];

endmodule

// File: rtl/ptlb_frame_store.sv
module ptlb_frame_store #(
    parameter int ENTRIES = 256,
    parameter int FRAME_W = 52,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [FRAME_W-1:0] wr_frame_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [FRAME_W-1:0] rd_frame_o
);

    logic [FRAME_W-1:0] frames_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            frames_q[wr_idx_i] <= wr_frame_i;
        end
    end

    assign rd_frame_o = frames_q[rd_idx_i];

endmodule

// File: rtl/ptlb_perm_check.sv
module ptlb_perm_check
    import ptlb_pkg::*;
(
    input  logic [PTE_W-1:0] pte_i,
    input  logic             sup_i,
    input  logic [1:0]       kind_i,
    output perm_t            fill_mask_o,
    output logic             fault_o,
    output cause_e           cause_o
);

    perm_t eff;
    perm_t need;

    always_comb begin
        eff         = effective_perm(pte_i, sup_i);
        need        = needed_perm(kind_i);
        fill_mask_o = eff;
        fault_o     = !pte_i[PTE_V_BIT] || ((eff & need) != need);
        cause_o     = fault_o ? fault_cause(kind_i) : CAUSE_NONE;
    end

endmodule

// File: rtl/ptlb_miss_ctrl.sv
module ptlb_miss_ctrl
    import ptlb_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid_i,
    input  logic [VA_W-1:0] req_vaddr_i,
    input  logic [1:0]      req_kind_i,
    input  logic            req_sup_i,
    input  logic            hit_i,
    input  logic            walk_resp_valid_i,
    output logic            idle_o,
    output logic            walking_o,
    output logic [VA_W-1:0] held_vaddr_o,
    output logic [1:0]      held_kind_o,
    output logic            held_sup_o
);

    miss_state_e state_q;
    logic [VA_W-1:0] vaddr_q;
    logic [1:0]      kind_q;
    logic            sup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            kind_q  <= '0;
            sup_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid_i && !hit_i) begin
                        state_q <= ST_WALK;
                        vaddr_q <= req_vaddr_i;
                        kind_q  <= req_kind_i;
                        sup_q   <= req_sup_i;
                    end
                end
                default: begin
                    if (walk_resp_valid_i) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign idle_o       = (state_q == ST_IDLE);
    assign walking_o    = (state_q == ST_WALK);
    assign held_vaddr_o = vaddr_q;
    assign held_kind_o  = kind_q;
    assign held_sup_o   = sup_q;

endmodule

// File: rtl/perm_tag_tlb.sv
module perm_tag_tlb
    import ptlb_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PG_SHIFT = 12,
    parameter int ENTRIES  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_kind_i,
    input  logic             req_sup_i,
    output logic             resp_valid_o,
    output logic             resp_fault_o,
    output logic [1:0]       resp_cause_o,
    output logic [PTE_W-1:0] resp_paddr_o,
    output logic [VA_W-1:0]  resp_badaddr_o,
    output logic             walk_req_valid_o,
    output logic [VA_W-1:0]  walk_req_vaddr_o,
    input  logic             walk_resp_valid_i,
    input  logic [PTE_W-1:0] walk_resp_pte_i
);

    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int VPN_W   = VA_W - PG_SHIFT;
    localparam int TAG_W   = VPN_W + 1;   // spare top bit keeps all-ones out of reach
    localparam int FRAME_W = PTE_W - PG_SHIFT;

    logic            idle, walking, held_sup, hit;
    logic [VA_W-1:0] held_vaddr;
    logic [1:0]      held_kind;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] look_tag, held_tag, sel_tag;
    logic [TAG_W-1:0] bank_rd [NUM_KINDS];
    logic [FRAME_W-1:0] rd_frame;

    perm_t  fill_mask;
    logic   chk_fault;
    cause_e chk_cause;
    logic   walk_done, fill_en;

    assign rd_idx   = req_vaddr_i[PG_SHIFT +: IDX_W];
    assign wr_idx   = held_vaddr[PG_SHIFT +: IDX_W];
    assign look_tag = {1'b0, req_vaddr_i[VA_W-1:PG_SHIFT]};
    assign held_tag = {1'b0, held_vaddr[VA_W-1:PG_SHIFT]};

    ptlb_miss_ctrl #(.VA_W(VA_W)) ctrl_i (
        .clk               (clk),
        .rst               (rst),
        .req_valid_i       (req_valid_i),
        .req_vaddr_i       (req_vaddr_i),
        .req_kind_i        (req_kind_i),
        .req_sup_i         (req_sup_i),
        .hit_i             (hit),
        .walk_resp_valid_i (walk_resp_valid_i),
        .idle_o            (idle),
        .walking_o         (walking),
        .held_vaddr_o      (held_vaddr),
        .held_kind_o       (held_kind),
        .held_sup_o        (held_sup)
    );

    ptlb_perm_check perm_i (
        .pte_i       (walk_resp_pte_i),
        .sup_i       (held_sup),
        .kind_i      (held_kind),
        .fill_mask_o (fill_mask),
        .fault_o     (chk_fault),
        .cause_o     (chk_cause)
    );

    assign walk_done = walking && walk_resp_valid_i;
    assign fill_en   = walk_done && !chk_fault;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
        ptlb_tag_bank #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) bank_i (
            .clk      (clk),
            .rst      (rst),
            .flush_i  (flush_i),
            .wr_en_i  (fill_en),
            .wr_idx_i (wr_idx),
            .wr_tag_i (fill_mask[k] ? held_tag : {TAG_W{1'b1}}),
            .rd_idx_i (rd_idx),
            .rd_tag_o (bank_rd[k])
        );
    end

    ptlb_frame_store #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W)) frame_i (
        .clk        (clk),
        .wr_en_i    (fill_en),
        .wr_idx_i   (wr_idx),
        .wr_frame_i (walk_resp_pte_i[PTE_W-1:PG_SHIFT]),
        .rd_idx_i   (rd_idx),
        .rd_frame_o (rd_frame)
    );

    assign sel_tag = bank_rd[bank_of(req_kind_i)];
    assign hit     = idle && req_valid_i && (sel_tag == look_tag);

    always_comb begin
        req_ready_o      = idle;
        walk_req_valid_o = walking;
        walk_req_vaddr_o = walking ? held_vaddr : '0;
        resp_valid_o     = hit || walk_done;
        resp_fault_o     = walk_done && chk_fault;
        resp_cause_o     = resp_fault_o ? chk_cause : CAUSE_NONE;
        resp_badaddr_o   = resp_fault_o ? held_vaddr : '0;
        if (hit) begin
            resp_paddr_o = {rd_frame, req_vaddr_i[PG_SHIFT-1:0]};
        end else if (fill_en) begin
            resp_paddr_o = {walk_resp_pte_i[PTE_W-1:PG_SHIFT], held_vaddr[PG_SHIFT-1:0]};
        end else begin
            resp_paddr_o = '0;
        end
    end

endmodule

// File: rtl/ptlb_checker.sv
module ptlb_checker
    import ptlb_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PG_SHIFT = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_i,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic [VA_W-1:0]  req_vaddr_i,
    input logic             resp_valid_o,
    input logic             resp_fault_o,
    input logic [1:0]       resp_cause_o,
    input logic [PTE_W-1:0] resp_paddr_o,
    input logic [VA_W-1:0]  resp_badaddr_o,
    input logic             walk_req_valid_o,
    input logic [VA_W-1:0]  walk_req_vaddr_o,
    input logic             walk_resp_valid_i
);

    a_r4_ready_low_walk: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid_o |-> !req_ready_o);

    a_r4_walk_addr_held: assert property (@(posedge clk) disable iff (rst)
        (walk_req_valid_o && !walk_resp_valid_i) |=> (walk_req_valid_o && $stable(walk_req_vaddr_o)));

    a_r4_miss_starts_walk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o && !resp_valid_o) |=> walk_req_valid_o);

    a_r3_hit_no_walk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o && resp_valid_o) |=> !walk_req_valid_o);

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_o && !resp_fault_o) |->
        (resp_paddr_o[PG_SHIFT-1:0] == (walk_req_valid_o ? walk_req_vaddr_o[PG_SHIFT-1:0]
                                                         : req_vaddr_i[PG_SHIFT-1:0])));

    a_r7_fault_on_walk_only: assert property (@(posedge clk) disable iff (rst)
        resp_fault_o |-> (resp_valid_o && walk_req_valid_o && walk_resp_valid_i));

    a_r7_fault_badaddr: assert property (@(posedge clk) disable iff (rst)
        resp_fault_o |-> (resp_badaddr_o == walk_req_vaddr_o));

    a_r7_cause_matches: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |-> (resp_fault_o == (resp_cause_o != 2'd0)));

    a_r9_no_hit_after_flush: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !(req_valid_i && req_ready_o && resp_valid_o));

endmodule

bind perm_tag_tlb ptlb_checker #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT)) chk_i (
    .clk               (clk),
    .rst               (rst),
    .flush_i           (flush_i),
    .req_valid_i       (req_valid_i),
    .req_ready_o       (req_ready_o),
    .req_vaddr_i       (req_vaddr_i),
    .resp_valid_o      (resp_valid_o),
    .resp_fault_o      (resp_fault_o),
    .resp_cause_o      (resp_cause_o),
    .resp_paddr_o      (resp_paddr_o),
    .resp_badaddr_o    (resp_badaddr_o),
    .walk_req_valid_o  (walk_req_valid_o),
    .walk_req_vaddr_o  (walk_req_vaddr_o),
    .walk_resp_valid_i (walk_resp_valid_i)
);

// File: tb/perm_tag_tlb_tb_top.sv
module perm_tag_tlb_tb_top;

    localparam logic [63:0] P_V  = 64'h01;
    localparam logic [63:0] P_UR = 64'h02;
    localparam logic [63:0] P_UW = 64'h04;
    localparam logic [63:0] P_UX = 64'h08;
    localparam logic [63:0] P_SX = 64'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [63:0] req_vaddr_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        req_sup_i = 1'b0;
    logic        resp_valid_o, resp_fault_o;
    logic [1:0]  resp_cause_o;
    logic [63:0] resp_paddr_o, resp_badaddr_o;
    logic        walk_req_valid_o;
    logic [63:0] walk_req_vaddr_o;
    logic        walk_resp_valid_i = 1'b0;
    logic [63:0] walk_resp_pte_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic        g_walked, g_fault, g_wait_ok;
    logic [1:0]  g_cause;
    logic [63:0] g_paddr, g_bad;

    always #10 clk = ~clk;

    perm_tag_tlb dut_i (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One lookup; if it misses, the bench walker answers with pte after a wait cycle.
    task automatic access(input logic [63:0] va, input logic [1:0] kind, input logic sup,
                          input logic [63:0] pte);
        @(negedge clk);
        req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind; req_sup_i = sup;
        #5;
        g_wait_ok = 1'b1;
        if (resp_valid_o) begin
            g_walked = 1'b0; g_fault = resp_fault_o; g_cause = resp_cause_o;
            g_paddr = resp_paddr_o; g_bad = resp_badaddr_o;
            @(negedge clk);
            req_valid_i = 1'b0;
        end else begin
            g_walked = 1'b1;
            @(negedge clk);
            req_vaddr_i = ~va; req_kind_i = 2'd1;  // stalled requester changes its inputs
            #1;
            g_wait_ok = !req_ready_o && walk_req_valid_o && (walk_req_vaddr_o == va) && !resp_valid_o;
            @(negedge clk);
            req_valid_i = 1'b0;
            g_wait_ok = g_wait_ok && walk_req_valid_o && (walk_req_vaddr_o == va);
            walk_resp_valid_i = 1'b1; walk_resp_pte_i = pte;
            #5;
            g_wait_ok = g_wait_ok && resp_valid_o;
            g_fault = resp_fault_o; g_cause = resp_cause_o;
            g_paddr = resp_paddr_o; g_bad = resp_badaddr_o;
            @(negedge clk);
            walk_resp_valid_i = 1'b0;
        end
    endtask

    task automatic flush_pulse();
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 ready after reset", {63'd0, req_ready_o}, 64'd1);
        check("R1 no response after reset", {63'd0, resp_valid_o}, 64'd0);
        check("R1 no walk after reset", {63'd0, walk_req_valid_o}, 64'd0);
        access(64'hFFFF_FFFF_FFFF_F123, 2'd0, 1'b0, 64'hFFFF_F000 | P_V | P_UR);
        check("R1 top page misses", {63'd0, g_walked}, 64'd1);
        check("R1 top page paddr", g_paddr, 64'hFFFF_F123);
    endtask

    task automatic t_load_fill_and_fault();
        logic [63:0] va = 64'h1234_5678;
        logic [63:0] pte = (64'hABCDE << 12) | P_V | P_UR;
        access(va, 2'd0, 1'b0, pte);
        check("R4 miss walks", {63'd0, g_walked}, 64'd1);
        check("R4 stall and held address", {63'd0, g_wait_ok}, 64'd1);
        check("R5 refill paddr", g_paddr, 64'hABCDE678);
        access(va, 2'd0, 1'b0, pte);
        check("R3 load hits", {63'd0, g_walked}, 64'd0);
        check("R3 hit paddr", g_paddr, 64'hABCDE678);
        access(va, 2'd1, 1'b0, pte);
        check("R5 store bank not filled", {63'd0, g_walked}, 64'd1);
        check("R7 store fault", {63'd0, g_fault}, 64'd1);
        check("R7 store cause", {62'd0, g_cause}, 64'd2);
        check("R7 bad address", g_bad, va);
        access(va, 2'd1, 1'b0, pte);
        check("R8 fault left no tag", {63'd0, g_walked}, 64'd1);
        access(va, 2'd0, 1'b0, pte);
        check("R8 load entry intact", {63'd0, g_walked}, 64'd0);
    endtask

    task automatic t_all_perms();
        logic [63:0] va = 64'h0000_0003_0000_0A00;
        logic [63:0] pte = (64'h55 << 12) | P_V | P_UR | P_UW | P_UX;
        access(va, 2'd2, 1'b0, pte);
        check("R5 fetch fills", {63'd0, g_walked}, 64'd1);
        access(va, 2'd0, 1'b0, pte);
        check("R5 load hits after fetch fill", {63'd0, g_walked}, 64'd0);
        access(va, 2'd1, 1'b0, pte);
        check("R5 store hits after fetch fill", {63'd0, g_walked}, 64'd0);
        check("R3 store hit paddr", g_paddr, 64'h55A00);
        access(va, 2'd3, 1'b0, pte);
        check("R5 kind 3 acts as load", {63'd0, g_walked}, 64'd0);
    endtask

    task automatic t_supervisor();
        logic [63:0] va = 64'h4000_0010;
        logic [63:0] pte = (64'h777 << 12) | P_V | P_UR | P_SX;
        access(va, 2'd2, 1'b1, pte);
        check("R6 supervisor fetch allowed", {63'd0, g_fault}, 64'd0);
        check("R6 supervisor fetch paddr", g_paddr, 64'h777010);
        access(va, 2'd0, 1'b1, pte);
        check("R6 supervisor load misses", {63'd0, g_walked}, 64'd1);
        check("R6 supervisor load faults", {62'd0, g_cause}, 64'd1);
        access(64'h5000_0000, 2'd2, 1'b0, P_V | P_SX);
        check("R6 user fetch of supervisor page", {62'd0, g_cause}, 64'd3);
    endtask

    task automatic t_alias();
        access(64'h0010_0000, 2'd0, 1'b0, (64'h11 << 12) | P_V | P_UR);
        access(64'h0020_0000, 2'd0, 1'b0, (64'h22 << 12) | P_V | P_UR);
        check("R2 alias page no false hit", {63'd0, g_walked}, 64'd1);
        access(64'h0010_1000, 2'd0, 1'b0, (64'h33 << 12) | P_V | P_UR);
        access(64'h0020_0004, 2'd0, 1'b0, 64'd0);
        check("R2 neighbour index kept", {63'd0, g_walked}, 64'd0);
        check("R2 alias paddr", g_paddr, 64'h22004);
        access(64'h0010_0000, 2'd0, 1'b0, (64'h11 << 12) | P_V | P_UR);
        check("R2 evicted page misses", {63'd0, g_walked}, 64'd1);
    endtask

    task automatic t_invalid_entry();
        access(64'h7000_0040, 2'd0, 1'b0, 64'd0);
        check("R7 invalid entry faults", {62'd0, g_cause}, 64'd1);
        check("R7 invalid entry bad address", g_bad, 64'h7000_0040);
    endtask

    task automatic t_flush();
        logic [63:0] va = 64'h9000_0000;
        logic [63:0] pte = (64'h99 << 12) | P_V | P_UR | P_UW | P_UX;
        access(va, 2'd0, 1'b0, pte);
        access(va, 2'd2, 1'b0, pte);
        check("R9 cached before flush", {63'd0, g_walked}, 64'd0);
        for (int k = 0; k < 3; k++) begin
            flush_pulse();
            access(va, 2'(k), 1'b0, pte);
            check($sformatf("R9 kind %0d misses after flush", k), {63'd0, g_walked}, 64'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        t_reset_state();
        t_load_fill_and_fault();
        t_all_perms();
        t_supervisor();
        t_alias();
        t_invalid_entry();
        t_flush();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule